// File: doc/BRIEF.md
# Dual-Channel Interrupt Source Selector

This block raises two independent, active-high interrupt requests for a digital I/O controller. Each channel holds a three-bit source code, loaded through a simple write strobe. The code picks what sets that channel's interrupt:

- a change on any line of a wide input group;
- a rising edge of a gated condition formed from two control pins;
- a falling edge on one control pin;
- a zero-reach pulse from an external counter or timer.

The remaining codes switch the channel off.

All inputs pass through one register stage. A second register holds the previous sample, and the edge and change detectors compare the two. A detected trigger sets a sticky pending flag, which drives the interrupt line until software clears it with a one-cycle clear strobe. When a channel's code is rewritten, its edge history is discarded. No event is recognised until two fresh samples have been taken, so the act of switching source cannot fake an edge.

Top module: `irq_src_sel`

## Requirements
- R1: After reset both interrupt outputs are low and both channels are switched off (code 4). Input activity then sets neither output.
- R2: Codes 4, 5, 6 and 7 switch a channel off. Group changes, control-pin edges and zero-reach pulses then never raise its output.
- R3: With code 0, a change in any bit of the channel's 48-bit group raises its output on the second rising clock edge after the change. Channel 0 watches `grp_a` and channel 1 watches `grp_b`.
- R4: With code 1, the channel triggers on a rising edge of (pin0 OR NOT pin3). This occurs when pin3 falls while pin0 is low, and when pin0 rises while pin3 is high. The latency is the same as in R3.
- R5: With code 1, no trigger occurs while pin0 stays high or while pin3 stays low, whatever the other pin does.
- R6: With code 2, a falling edge of pin0 triggers and a rising edge does not.
- R7: With code 3, channel 0 triggers on `tc_cnt` and channel 1 triggers on `tc_tmr`. Each channel ignores the other pulse.
- R8: The pending flag holds until `clr_pend[ch]` is high for a cycle. A trigger in that same cycle keeps the flag set.
- R9: A code write discards the channel's history. An input change made in the cycle after the write edge is never reported, and later changes are reported normally.
- R10: The channels are independent. One channel's code, inputs and clear strobe leave the other channel's output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Source-code write strobe |
| cfg_wr_ch | input | 1 | Channel addressed by the write |
| cfg_wr_data | input | 3 | Source code to load |
| clr_pend | input | 2 | Per-channel clear strobe for the pending flag |
| grp_a | input | 48 | Input group watched by channel 0 |
| grp_b | input | 48 | Input group watched by channel 1 |
| ctl_a0 | input | 1 | Channel 0 pin0 |
| ctl_a3 | input | 1 | Channel 0 pin3 |
| ctl_b0 | input | 1 | Channel 1 pin0 |
| ctl_b3 | input | 1 | Channel 1 pin3 |
| tc_cnt | input | 1 | Counter zero-reach pulse |
| tc_tmr | input | 1 | Timer zero-reach pulse |
| irq | output | 2 | Interrupt requests, one per channel |

## Verification
The hardest situation to reach from the ports is the collision of a clear strobe with a fresh trigger in the same cycle. The bench first sets the flag with a zero-reach pulse. It then issues a second pulse and places the clear strobe exactly one cycle after it, the cycle in which the registered pulse is live, and checks that the flag survives. The blind window after a code write is reached in a similar way: the bench changes the group in the first cycle after the write edge and confirms that the change is never reported.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    SRC_COS  = 3'd0,
    SRC_GATE = 3'd1,
    SRC_FALL = 3'd2,
    SRC_TC   = 3'd3,
    SRC_OFF  = 3'd4
  } src_mode_e;

  function automatic logic mode_live(input logic [MODE_W-1:0] m);
    return (m < MODE_W'(SRC_OFF));
  endfunction
endpackage

// File: rtl/irq_mode_reg.sv
module irq_mode_reg
  import irq_sel_pkg::*;
#(
  parameter logic [MODE_W-1:0] RST_CODE = SRC_OFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [MODE_W-1:0] wr_data,
  output logic [MODE_W-1:0] mode_q,
  output logic              hist_clr
);
  logic [MODE_W-1:0] mode_d;

  always_comb begin
    mode_d = mode_q;
    if (wr_stb) mode_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= RST_CODE;
    else        mode_q <= mode_d;
  end

  assign hist_clr = wr_stb;

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(mode_q));
endmodule

// File: rtl/irq_trig_det.sv
module irq_trig_det
  import irq_sel_pkg::*;
#(
  parameter int GRP_W  = 48,
  parameter int WARM_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic              hist_clr,
  input  logic [GRP_W-1:0]  grp_in,
  input  logic              c0_in,
  input  logic              c3_in,
  input  logic              tc_in,
  output logic              trig
);
  localparam int WC_W = $clog2(WARM_N + 1);
  localparam logic [WC_W-1:0] WARM_DONE = WC_W'(WARM_N);

  logic [GRP_W-1:0] grp_s1, grp_s2;
  logic             c0_s1, c0_s2, c3_s1, c3_s2, tc_s1;
  logic [WC_W-1:0]  warm_q, warm_d;
  logic             warm_ok, f_now, f_prv;
  logic             cos_hit, gate_hit, fall_hit;

  // warm-up counter: history is valid only once WARM_N samples follow a clear
  always_comb begin
    warm_d = warm_q;
    if (hist_clr)                warm_d = '0;
    else if (warm_q != WARM_DONE) warm_d = warm_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_s1 <= '0;
      grp_s2 <= '0;
      c0_s1  <= 1'b0;
      c0_s2  <= 1'b0;
      c3_s1  <= 1'b0;
      c3_s2  <= 1'b0;
      tc_s1  <= 1'b0;
      warm_q <= '0;
    end else begin
      grp_s1 <= grp_in;
      grp_s2 <= grp_s1;
      c0_s1  <= c0_in;
      c0_s2  <= c0_s1;
      c3_s1  <= c3_in;
      c3_s2  <= c3_s1;
      tc_s1  <= tc_in;
      warm_q <= warm_d;
    end
  end

  always_comb begin
    warm_ok  = (warm_q == WARM_DONE);
    f_now    = c0_s1 | ~c3_s1;
    f_prv    = c0_s2 | ~c3_s2;
    cos_hit  = warm_ok && (grp_s1 != grp_s2);
    gate_hit = warm_ok && f_now && !f_prv;
    fall_hit = warm_ok && !c0_s1 && c0_s2;
    case (mode)
      SRC_COS:  trig = cos_hit;
      SRC_GATE: trig = gate_hit;
      SRC_FALL: trig = fall_hit;
      SRC_TC:   trig = tc_s1;
      default:  trig = 1'b0;
    endcase
  end

  p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_live(mode) |-> !trig);
  p_gate_c0_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SRC_GATE && c0_s1 && c0_s2) |-> !trig);
  p_gate_c3_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SRC_GATE && !c3_s1 && !c3_s2) |-> !trig);
  p_blind_after_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hist_clr |=> (!cos_hit && !gate_hit && !fall_hit));
endmodule

// File: rtl/irq_pend.sv
module irq_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic clr,
  output logic pend
);
  logic pend_d;

  always_comb begin
    pend_d = pend;
    if (clr)  pend_d = 1'b0;
    if (trig) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_d;
  end

  p_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> pend);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !trig) |=> !pend);
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr) |=> pend);
endmodule

// File: rtl/irq_src_sel.sv
module irq_src_sel
  import irq_sel_pkg::*;
#(
  parameter int GRP_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic              cfg_wr_ch,
  input  logic [MODE_W-1:0] cfg_wr_data,
  input  logic [1:0]        clr_pend,
  input  logic [GRP_W-1:0]  grp_a,
  input  logic [GRP_W-1:0]  grp_b,
  input  logic              ctl_a0,
  input  logic              ctl_a3,
  input  logic              ctl_b0,
  input  logic              ctl_b3,
  input  logic              tc_cnt,
  input  logic              tc_tmr,
  output logic [1:0]        irq
);
  localparam int N_CH = 2;

  logic [GRP_W-1:0]  grp_v  [N_CH];
  logic [N_CH-1:0]   c0_v, c3_v, tc_v, wr_v, clr_h, trig_v;
  logic [MODE_W-1:0] mode_v [N_CH];

  assign grp_v[0] = grp_a;
  assign grp_v[1] = grp_b;
  assign c0_v     = {ctl_b0, ctl_a0};
  assign c3_v     = {ctl_b3, ctl_a3};
  assign tc_v     = {tc_tmr, tc_cnt};

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    assign wr_v[ch] = cfg_wr_en && (cfg_wr_ch == 1'(ch));

    irq_mode_reg u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_stb   (wr_v[ch]),
      .wr_data  (cfg_wr_data),
      .mode_q   (mode_v[ch]),
      .hist_clr (clr_h[ch])
    );

    irq_trig_det #(.GRP_W(GRP_W)) u_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode_v[ch]),
      .hist_clr (clr_h[ch]),
      .grp_in   (grp_v[ch]),
      .c0_in    (c0_v[ch]),
      .c3_in    (c3_v[ch]),
      .tc_in    (tc_v[ch]),
      .trig     (trig_v[ch])
    );

    irq_pend u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .trig  (trig_v[ch]),
      .clr   (clr_pend[ch]),
      .pend  (irq[ch])
    );

    p_off_no_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_live(mode_v[ch]) && !irq[ch]) |=> !irq[ch]);
  end
endmodule

// File: tb/tb_irq_src_sel.sv
module tb_irq_src_sel;
  localparam int PERIOD = 10;
  localparam int GW = 48;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr_en = 1'b0;
  logic          cfg_wr_ch = 1'b0;
  logic [2:0]    cfg_wr_data = 3'd0;
  logic [1:0]    clr_pend = 2'b00;
  logic [GW-1:0] grp_a = '0;
  logic [GW-1:0] grp_b = '0;
  logic          ctl_a0 = 1'b0, ctl_a3 = 1'b0, ctl_b0 = 1'b0, ctl_b3 = 1'b0;
  logic          tc_cnt = 1'b0, tc_tmr = 1'b0;
  logic [1:0]    irq;

  int n_chk = 0;
  int n_bad = 0;

  always #(PERIOD/2) clk = ~clk;

  irq_src_sel #(.GRP_W(GW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_ch(cfg_wr_ch),
    .cfg_wr_data(cfg_wr_data), .clr_pend(clr_pend), .grp_a(grp_a), .grp_b(grp_b),
    .ctl_a0(ctl_a0), .ctl_a3(ctl_a3), .ctl_b0(ctl_b0), .ctl_b3(ctl_b3),
    .tc_cnt(tc_cnt), .tc_tmr(tc_tmr), .irq(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic got, input logic exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: irq got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic wr_mode(input logic ch, input logic [2:0] code);
    cfg_wr_en = 1'b1; cfg_wr_ch = ch; cfg_wr_data = code;
    tick(1);
    cfg_wr_en = 1'b0;
  endtask

  task automatic set_mode(input logic ch, input logic [2:0] code);
    wr_mode(ch, code);
    tick(3);
  endtask

  task automatic clr_all();
    clr_pend = 2'b11; tick(1); clr_pend = 2'b00;
  endtask

  task automatic pulse_cnt(); tc_cnt = 1'b1; tick(1); tc_cnt = 1'b0; endtask
  task automatic pulse_tmr(); tc_tmr = 1'b1; tick(1); tc_tmr = 1'b0; endtask

  task automatic t_reset();
    check(irq[0], 1'b0, "R1 ch0 after reset");
    check(irq[1], 1'b0, "R1 ch1 after reset");
    grp_a = ~grp_a; grp_b = ~grp_b; pulse_cnt(); pulse_tmr();
    ctl_a0 = 1'b1; ctl_b0 = 1'b1; tick(2); ctl_a0 = 1'b0; ctl_b0 = 1'b0; tick(3);
    check(irq[0], 1'b0, "R1 ch0 off by default");
    check(irq[1], 1'b0, "R1 ch1 off by default");
  endtask

  task automatic t_disable();
    for (int c = 4; c < 8; c++) begin
      set_mode(1'b0, 3'(c));
      grp_a[5] = ~grp_a[5]; tick(2);
      pulse_cnt(); tick(2);
      ctl_a3 = 1'b1; ctl_a0 = 1'b1; tick(2); ctl_a0 = 1'b0; tick(3);
      ctl_a3 = 1'b0; tick(3);
      check(irq[0], 1'b0, $sformatf("R2 code %0d stays off", c));
    end
  endtask

  task automatic t_cos();
    set_mode(1'b0, 3'd0);
    set_mode(1'b1, 3'd0);
    clr_all();
    grp_a[47] = ~grp_a[47];
    tick(1); check(irq[0], 1'b0, "R3 not yet after one edge");
    tick(1); check(irq[0], 1'b1, "R3 bit47 change ch0");
    check(irq[1], 1'b0, "R10 ch1 ignores grp_a");
    clr_all(); tick(1);
    grp_a[0] = ~grp_a[0]; tick(2);
    check(irq[0], 1'b1, "R3 bit0 change ch0");
    clr_all(); tick(1);
    grp_b[24] = ~grp_b[24]; tick(2);
    check(irq[1], 1'b1, "R3 bit24 change ch1");
    check(irq[0], 1'b0, "R10 ch0 ignores grp_b");
    clr_all(); tick(2);
  endtask

  task automatic t_gate();
    ctl_a0 = 1'b0; ctl_a3 = 1'b1;
    set_mode(1'b0, 3'd1);
    clr_all(); tick(1);
    ctl_a3 = 1'b0; tick(2);
    check(irq[0], 1'b1, "R4 pin3 fall with pin0 low");
    clr_all(); tick(1);
    ctl_a3 = 1'b1; tick(3);
    check(irq[0], 1'b0, "R4 pin3 rise gives no trigger");
    ctl_a0 = 1'b1; tick(2);
    check(irq[0], 1'b1, "R4 pin0 rise with pin3 high");
    clr_all(); tick(1);
    ctl_a3 = 1'b0; tick(2); ctl_a3 = 1'b1; tick(2); ctl_a3 = 1'b0; tick(3);
    check(irq[0], 1'b0, "R5 pin0 high masks pin3 edges");
    ctl_a0 = 1'b0; tick(2); ctl_a0 = 1'b1; tick(2); ctl_a0 = 1'b0; tick(3);
    check(irq[0], 1'b0, "R5 pin3 low masks pin0 edges");
  endtask

  task automatic t_fall();
    ctl_b0 = 1'b0;
    set_mode(1'b1, 3'd2);
    clr_all(); tick(1);
    ctl_b0 = 1'b1; tick(3);
    check(irq[1], 1'b0, "R6 rising pin0 ignored");
    ctl_b0 = 1'b0; tick(2);
    check(irq[1], 1'b1, "R6 falling pin0 triggers");
    clr_all(); tick(1);
  endtask

  task automatic t_tc();
    set_mode(1'b0, 3'd3);
    set_mode(1'b1, 3'd3);
    clr_all(); tick(1);
    pulse_tmr(); tick(2);
    check(irq[0], 1'b0, "R7 ch0 ignores timer pulse");
    check(irq[1], 1'b1, "R7 ch1 timer pulse");
    clr_all(); tick(1);
    pulse_cnt(); tick(1);
    check(irq[0], 1'b1, "R7 ch0 counter pulse");
    check(irq[1], 1'b0, "R7 ch1 ignores counter pulse");
  endtask

  task automatic t_sticky();
    tick(6);
    check(irq[0], 1'b1, "R8 pending holds");
    clr_pend = 2'b10; tick(1); clr_pend = 2'b00;
    check(irq[0], 1'b1, "R10 ch1 clear leaves ch0");
    // collision: pulse registered at next edge, clear in the cycle after
    tc_cnt = 1'b1; tick(1); tc_cnt = 1'b0;
    clr_pend = 2'b01; tick(1); clr_pend = 2'b00;
    check(irq[0], 1'b1, "R8 trigger beats same-cycle clear");
    clr_pend = 2'b01; tick(1); clr_pend = 2'b00;
    check(irq[0], 1'b0, "R8 clear drops pending");
  endtask

  task automatic t_blind();
    set_mode(1'b0, 3'd0);
    clr_all(); tick(1);
    wr_mode(1'b0, 3'd0);
    grp_a[12] = ~grp_a[12];
    tick(5);
    check(irq[0], 1'b0, "R9 change right after write ignored");
    grp_a[13] = ~grp_a[13]; tick(2);
    check(irq[0], 1'b1, "R9 later change reported");
    clr_all();
  endtask

  initial begin
    #(PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_disable();
    t_cos();
    t_gate();
    t_fall();
    t_tc();
    t_sticky();
    t_blind();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule